// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sends one command to a memory card each time the host writes a command word with its start bit set. The host gives a 6-bit command index, a few control flags and a 32-bit argument. The block holds the request toward a card model until the card finishes its reply. It counts and stores the reply bytes, then checks the reply length against the kind of response the command asked for. On a valid reply it loads four 32-bit response words. It then raises exactly one of three one-cycle completion pulses: sent, response-end or timeout.

The card side is a plain request/reply handshake. While `card_req` is high, the card delivers reply bytes one per cycle on `card_byte_vld`/`card_byte`. It then pulses `card_done`, and can raise `card_no_rsp` in that cycle to report that nothing came back. If the card stays silent for `RSP_WAIT_MAX` cycles, the block ends the command as a timeout. While a command is in flight, `busy` is high and further command writes are dropped.

Top module: `card_cmd_unit`

## Requirements
- R1: A command write while `busy` is low stores the 11-bit word on `cmd_stored`. Its fields are: index in bits 5:0, expect-response in bit 6, long-response in bit 7, interrupt-mode in bit 8, hold in bit 9 and start in bit 10. If start is set and hold is clear, `card_req` is high from the next cycle and carries the index and the argument. The interrupt-mode bit has no effect. A write with start clear issues nothing.
- R2: `busy` is low after reset and rises in the cycle after an accepted start. It falls in the same cycle as the completion pulse.
- R3: If no response is expected and the card completes without reporting no-response, `st_sent` pulses and the response words keep their values.
- R4: A 4-byte reply to a short request pulses `st_rsp_end` and loads word 0 big-endian (first byte in bits 31:24). Words 1 to 3 become zero.
- R5: A 16-byte reply to a request that expects a response loads words 0 to 3 big-endian from consecutive bytes, with bit 0 of word 3 forced to zero, and pulses `st_rsp_end`.
- R6: A request that expects a response pulses `st_timeout` in three cases: zero bytes, 4 bytes to a long request, or any count other than 4 or 16. The response words keep their values.
- R7: A completion with `card_no_rsp` high pulses `st_timeout` whatever the flags and byte count, and leaves the response words unchanged.
- R8: If the card never completes, `st_timeout` pulses after `busy` has been high for exactly `RSP_WAIT_MAX` cycles.
- R9: At completion the start bit of `cmd_stored` clears and bits 9:0 are kept.
- R10: A write with start and hold both set issues no request and raises no status. It is stored with the start bit already clear.
- R11: Command writes while `busy` is high are ignored. The stored word, the argument and the request are unchanged.
- R12: Each issued command gives exactly one completion pulse, one cycle long, and the three pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_word | input | 11 | Command word (index and flags) |
| cmd_arg | input | 32 | Command argument |
| cmd_stored | output | 11 | Stored command word, start bit self-clearing |
| busy | output | 1 | Command in flight |
| card_req | output | 1 | Request to the card, held until completion |
| card_index | output | 6 | Command index toward the card |
| card_arg | output | 32 | Argument toward the card |
| card_byte_vld | input | 1 | Reply byte valid |
| card_byte | input | 8 | Reply byte |
| card_done | input | 1 | Card finished the reply |
| card_no_rsp | input | 1 | Card reports no response (with `card_done`) |
| rsp_w0 | output | 32 | Response word 0 |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |
| st_sent | output | 1 | Command-sent pulse |
| st_rsp_end | output | 1 | Response-received pulse |
| st_timeout | output | 1 | Timeout pulse |

## Verification
The bench builds the block with `RSP_WAIT_MAX` set to 24, so a silent card ends within a few dozen cycles. That makes the exact length of the busy window in the timeout case cheap to measure. The byte-count saturation point stays reachable with a 20-byte reply. The replies are chosen to cover every length class: 0, 4, 7, 16 and 20 bytes. They are crossed with short and long requests and with the no-response flag. A long reply whose last byte is odd shows that the forced-zero bit works.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_BITS        = 11;
    localparam int IDX_BITS        = 6;
    localparam int WORD_BITS       = 32;
    localparam int RSP_SHORT_BYTES = 4;
    localparam int RSP_LONG_BYTES  = 16;
    localparam int RSP_WORDS       = RSP_LONG_BYTES / 4;
    localparam int RSP_FLAT_BITS   = RSP_LONG_BYTES * 8;
    // counter saturates one past the long length to mark "too many"
    localparam int CNT_W           = $clog2(RSP_LONG_BYTES + 2);

    // bit 10 start, 9 hold, 8 interrupt mode, 7 long, 6 expect, 5:0 index
    typedef struct packed {
        logic                start;
        logic                hold;
        logic                irq_mode;
        logic                long_rsp;
        logic                want_rsp;
        logic [IDX_BITS-1:0] index;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_SENT = 2'd1,
        OUT_RSP  = 2'd2,
        OUT_TMO  = 2'd3
    } outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;

    function automatic outcome_e judge_reply(
        input logic             want,
        input logic             long_rsp,
        input logic             no_rsp,
        input logic [CNT_W-1:0] n
    );
        outcome_e r;
        if (no_rsp)
            r = OUT_TMO;
        else if (!want)
            r = OUT_SENT;
        else if (n == CNT_W'(RSP_LONG_BYTES))
            r = OUT_RSP;
        else if (n == CNT_W'(RSP_SHORT_BYTES) && !long_rsp)
            r = OUT_RSP;
        else
            r = OUT_TMO;
        return r;
    endfunction

    // word k of the reply: byte 4k lands in bits 31:24
    function automatic logic [WORD_BITS-1:0] be_word(
        input logic [RSP_FLAT_BITS-1:0] flat,
        input int                       k
    );
        return flat[(RSP_WORDS-1-k)*WORD_BITS +: WORD_BITS];
    endfunction

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
    import sdcmd_pkg::*;
#(
    parameter int RSP_WAIT_MAX = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [CMD_BITS-1:0]  cmd_word,
    input  logic [WORD_BITS-1:0] cmd_arg,
    input  logic                 card_done,
    input  logic                 card_no_rsp,
    input  logic [CNT_W-1:0]     byte_cnt,
    output logic [CMD_BITS-1:0]  cmd_stored,
    output logic [WORD_BITS-1:0] arg_stored,
    output logic                 waiting,
    output logic                 start_evt,
    output logic                 commit,
    output outcome_e             outcome
);

    localparam int WAIT_W = $clog2(RSP_WAIT_MAX + 1);

    ctrl_state_e       state_q;
    cmd_fields_t       cmd_q;
    cmd_fields_t       wr_f;
    logic [WAIT_W-1:0] wait_cnt;
    logic              accept;
    logic              expired;

    assign wr_f      = cmd_fields_t'(cmd_word);
    assign accept    = cmd_wr && (state_q == ST_IDLE);
    assign start_evt = accept && wr_f.start && !wr_f.hold;
    assign expired   = (wait_cnt == WAIT_W'(RSP_WAIT_MAX - 1));
    assign commit    = (state_q == ST_WAIT) && (card_done || expired);

    always_comb begin
        if (card_done)
            outcome = judge_reply(cmd_q.want_rsp, cmd_q.long_rsp, card_no_rsp, byte_cnt);
        else
            outcome = OUT_TMO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cmd_q      <= '0;
            arg_stored <= '0;
            wait_cnt   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_q       <= wr_f;
                        cmd_q.start <= wr_f.start && !wr_f.hold;
                        arg_stored  <= cmd_arg;
                    end
                    if (start_evt) begin
                        state_q  <= ST_WAIT;
                        wait_cnt <= '0;
                    end
                end
                ST_WAIT: begin
                    if (commit) begin
                        state_q     <= ST_IDLE;
                        cmd_q.start <= 1'b0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_stored = CMD_BITS'(cmd_q);
    assign waiting    = (state_q == ST_WAIT);

endmodule

// File: rtl/sdcmd_rsp_gather.sv
module sdcmd_rsp_gather
    import sdcmd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     capture,
    input  logic [7:0]               in_byte,
    output logic [CNT_W-1:0]         byte_cnt,
    output logic [RSP_FLAT_BITS-1:0] flat
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            byte_cnt <= '0;
        else if (capture && byte_cnt <= CNT_W'(RSP_LONG_BYTES))
            byte_cnt <= byte_cnt + 1'b1;
    end

    for (genvar i = 0; i < RSP_LONG_BYTES; i++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (capture && byte_cnt == CNT_W'(i))
                slot_q <= in_byte;
        end
        assign flat[(RSP_LONG_BYTES-1-i)*8 +: 8] = slot_q;
    end

endmodule

// File: rtl/sdcmd_rsp_regs.sv
module sdcmd_rsp_regs
    import sdcmd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit,
    input  outcome_e                 outcome,
    input  logic [CNT_W-1:0]         byte_cnt,
    input  logic [RSP_FLAT_BITS-1:0] flat,
    output logic [WORD_BITS-1:0]     words [RSP_WORDS]
);

    logic load;
    logic full_len;

    assign load     = commit && (outcome == OUT_RSP);
    assign full_len = (byte_cnt == CNT_W'(RSP_LONG_BYTES));

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        logic [WORD_BITS-1:0] nxt;
        always_comb begin
            if (k == 0)
                nxt = be_word(flat, k);
            else if (!full_len)
                nxt = '0;
            else if (k == RSP_WORDS - 1)
                nxt = be_word(flat, k) & ~WORD_BITS'(1);
            else
                nxt = be_word(flat, k);
        end
        always_ff @(posedge clk) begin
            if (rst)
                words[k] <= '0;
            else if (load)
                words[k] <= nxt;
        end
    end

endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
    import sdcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  outcome_e outcome,
    output logic     st_sent,
    output logic     st_rsp_end,
    output logic     st_timeout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_sent    <= 1'b0;
            st_rsp_end <= 1'b0;
            st_timeout <= 1'b0;
        end else begin
            st_sent    <= commit && (outcome == OUT_SENT);
            st_rsp_end <= commit && (outcome == OUT_RSP);
            st_timeout <= commit && (outcome == OUT_TMO);
        end
    end

endmodule

// File: rtl/card_cmd_unit.sv
module card_cmd_unit
    import sdcmd_pkg::*;
#(
    parameter int RSP_WAIT_MAX = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [10:0]          cmd_word,
    input  logic [31:0]          cmd_arg,
    output logic [10:0]          cmd_stored,
    output logic                 busy,
    output logic                 card_req,
    output logic [5:0]           card_index,
    output logic [31:0]          card_arg,
    input  logic                 card_byte_vld,
    input  logic [7:0]           card_byte,
    input  logic                 card_done,
    input  logic                 card_no_rsp,
    output logic [31:0]          rsp_w0,
    output logic [31:0]          rsp_w1,
    output logic [31:0]          rsp_w2,
    output logic [31:0]          rsp_w3,
    output logic                 st_sent,
    output logic                 st_rsp_end,
    output logic                 st_timeout
);

    logic                     waiting;
    logic                     start_evt;
    logic                     commit;
    outcome_e                 outcome;
    logic [CNT_W-1:0]         byte_cnt;
    logic [RSP_FLAT_BITS-1:0] flat;
    logic [WORD_BITS-1:0]     words [RSP_WORDS];
    logic                     capture;

    sdcmd_ctrl #(.RSP_WAIT_MAX(RSP_WAIT_MAX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_word   (cmd_word),
        .cmd_arg    (cmd_arg),
        .card_done  (card_done),
        .card_no_rsp(card_no_rsp),
        .byte_cnt   (byte_cnt),
        .cmd_stored (cmd_stored),
        .arg_stored (card_arg),
        .waiting    (waiting),
        .start_evt  (start_evt),
        .commit     (commit),
        .outcome    (outcome)
    );

    // bytes arriving with the done strobe are not part of the reply
    assign capture = waiting && card_byte_vld && !card_done;

    sdcmd_rsp_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_evt),
        .capture (capture),
        .in_byte (card_byte),
        .byte_cnt(byte_cnt),
        .flat    (flat)
    );

    sdcmd_rsp_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .outcome (outcome),
        .byte_cnt(byte_cnt),
        .flat    (flat),
        .words   (words)
    );

    sdcmd_status u_status (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .outcome   (outcome),
        .st_sent   (st_sent),
        .st_rsp_end(st_rsp_end),
        .st_timeout(st_timeout)
    );

    assign busy       = waiting;
    assign card_req   = waiting;
    assign card_index = cmd_stored[IDX_BITS-1:0];
    assign rsp_w0     = words[0];
    assign rsp_w1     = words[1];
    assign rsp_w2     = words[2];
    assign rsp_w3     = words[3];

endmodule

// File: rtl/card_cmd_unit_chk.sv
module card_cmd_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic [10:0] cmd_word,
    input logic [10:0] cmd_stored,
    input logic        busy,
    input logic        card_req,
    input logic [31:0] rsp_w3,
    input logic        st_sent,
    input logic        st_rsp_end,
    input logic        st_timeout
);

    // R12: never two completion pulses together
    a_r12_one_status: assert property (@(posedge clk) disable iff (rst)
        $countones({st_sent, st_rsp_end, st_timeout}) <= 1);

    // R12: a pulse lasts one cycle
    a_r12_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (st_sent || st_rsp_end || st_timeout) |=> !(st_sent || st_rsp_end || st_timeout));

    // R2: busy falls together with a completion pulse
    a_r2_busy_fall_status: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (st_sent || st_rsp_end || st_timeout));

    // R2/R1: accepted start raises busy and the request
    a_r1_start_issues: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && cmd_word[10] && !cmd_word[9]) |=> (busy && card_req));

    // R10: hold flag suppresses issue and clears start
    a_r10_hold_no_issue: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && cmd_word[10] && cmd_word[9]) |=> (!busy && !cmd_stored[10]));

    // R11: stored fields do not move while a command is in flight
    a_r11_ignore_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cmd_stored[9:0] == $past(cmd_stored[9:0])));

    // R9: start bit is clear once the command has completed
    a_r9_start_cleared: assert property (@(posedge clk) disable iff (rst)
        (st_sent || st_rsp_end || st_timeout) |-> !cmd_stored[10]);

    // R3: sent only when no response was asked for
    a_r3_sent_no_expect: assert property (@(posedge clk) disable iff (rst)
        st_sent |-> !cmd_stored[6]);

    // R5: long response never leaves bit 0 of word 3 set
    a_r5_w3_bit0: assert property (@(posedge clk) disable iff (rst)
        (st_rsp_end && cmd_stored[7]) |-> !rsp_w3[0]);

endmodule

bind card_cmd_unit card_cmd_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_word  (cmd_word),
    .cmd_stored(cmd_stored),
    .busy      (busy),
    .card_req  (card_req),
    .rsp_w3    (rsp_w3),
    .st_sent   (st_sent),
    .st_rsp_end(st_rsp_end),
    .st_timeout(st_timeout)
);

// File: tb/card_cmd_unit_tb.sv
module card_cmd_unit_tb;

    localparam int WAIT_MAX = 24;
    localparam int K_SENT = 1, K_RSP = 2, K_TMO = 3;

    typedef struct packed {
        logic [1:0]   kind;
        logic [127:0] w;
        logic [10:0]  stored;
        logic [7:0]   tag;
    } sb_item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_wr = 0;
    logic [10:0] cmd_word = 0;
    logic [31:0] cmd_arg = 0;
    logic [10:0] cmd_stored;
    logic        busy, card_req;
    logic [5:0]  card_index;
    logic [31:0] card_arg;
    logic        card_byte_vld = 0;
    logic [7:0]  card_byte = 0;
    logic        card_done = 0;
    logic        card_no_rsp = 0;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
    logic        st_sent, st_rsp_end, st_timeout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;
    sb_item_t    sbq[$];
    logic [127:0] exp_w = '0;

    always #10 clk = ~clk;

    card_cmd_unit #(.RSP_WAIT_MAX(WAIT_MAX)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (st_sent || st_rsp_end || st_timeout)) begin
            if (sbq.size() == 0) begin
                chk(0, "R12 unexpected completion", {st_sent, st_rsp_end, st_timeout}, 0);
            end else begin
                sb_item_t it;
                logic [1:0] k;
                it = sbq.pop_front();
                k = st_sent ? 2'(K_SENT) : (st_rsp_end ? 2'(K_RSP) : 2'(K_TMO));
                chk($countones({st_sent, st_rsp_end, st_timeout}) == 1, "R12 one pulse",
                    {st_sent, st_rsp_end, st_timeout}, 0);
                chk(k == it.kind, $sformatf("R%0d status kind", it.tag), k, it.kind);
                chk({rsp_w0, rsp_w1, rsp_w2, rsp_w3} == it.w, $sformatf("R%0d response words", it.tag),
                    {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, it.w);
                chk(cmd_stored == it.stored, "R9 stored word after completion", cmd_stored, it.stored);
                chk(!busy, "R2 busy low at completion", busy, 0);
            end
        end
    end

    function automatic logic [7:0] gen_byte(input logic [7:0] seed, input int i);
        return 8'(seed + i * 8'h1d);
    endfunction

    // driver: computes the expected outcome, pushes it, plays the card
    task automatic run_cmd(input logic [10:0] word, input logic [31:0] arg, input int n,
                           input bit no_rsp, input logic [7:0] seed, input bit silent,
                           input logic [7:0] tag);
        sb_item_t it;
        logic [7:0] b [20];
        int busy_cycles;
        bit want, lng;
        want = word[6];
        lng  = word[7];
        for (int i = 0; i < 20; i++) b[i] = gen_byte(seed, i);
        if (silent || no_rsp) it.kind = 2'(K_TMO);
        else if (!want) it.kind = 2'(K_SENT);
        else if (n == 16 || (n == 4 && !lng)) it.kind = 2'(K_RSP);
        else it.kind = 2'(K_TMO);
        if (it.kind == 2'(K_RSP)) begin
            exp_w = '0;
            exp_w[127:96] = {b[0], b[1], b[2], b[3]};
            if (n == 16) begin
                exp_w[95:64] = {b[4], b[5], b[6], b[7]};
                exp_w[63:32] = {b[8], b[9], b[10], b[11]};
                exp_w[31:0]  = {b[12], b[13], b[14], b[15] & 8'hfe};
            end
        end
        it.w = exp_w;
        it.stored = word & 11'h3ff;
        it.tag = tag;
        sbq.push_back(it);

        cmd_word = word; cmd_arg = arg; cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        chk(busy && card_req, "R2 busy and request after start", {busy, card_req}, 2'b11);
        chk(card_index == word[5:0], "R1 card index", card_index, word[5:0]);
        chk(card_arg == arg, "R1 card argument", card_arg, arg);
        if (silent) begin
            busy_cycles = 0;
            while (busy && busy_cycles < 1000) begin
                busy_cycles++;
                @(negedge clk);
            end
            chk(busy_cycles == WAIT_MAX, "R8 busy window length", busy_cycles, WAIT_MAX);
        end else begin
            for (int i = 0; i < n; i++) begin
                card_byte_vld = 1; card_byte = b[i];
                @(negedge clk);
            end
            card_byte_vld = 0;
            card_done = 1; card_no_rsp = no_rsp;
            @(negedge clk);
            card_done = 0; card_no_rsp = 0;
        end
        @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        chk(!busy && !card_req, "R2 reset busy/request", {busy, card_req}, 0);
        chk({st_sent, st_rsp_end, st_timeout} == 0, "R12 reset status", {st_sent, st_rsp_end, st_timeout}, 0);
        chk({rsp_w0, rsp_w1, rsp_w2, rsp_w3} == 0, "R4 reset responses", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, 0);
        chk(cmd_stored == 0, "R1 reset stored", cmd_stored, 0);

        // R3 no response expected, interrupt flag set (R1: no effect)
        run_cmd(11'h400 | 11'h100 | 11'd0, 32'h0000_0000, 0, 0, 8'h00, 0, 3);
        // R4 short response
        run_cmd(11'h400 | 11'h040 | 11'd17, 32'hdead_beef, 4, 0, 8'h10, 0, 4);
        // R5 long response, last byte odd
        run_cmd(11'h400 | 11'h0c0 | 11'd2, 32'h1234_5678, 16, 0, 8'h32, 0, 5);
        chk(exp_w[0] == 0 && gen_byte(8'h32, 15)[0], "R5 bit 0 forced", rsp_w3[0], 0);
        // R4 short after long clears words 1-3
        run_cmd(11'h400 | 11'h040 | 11'd13, 32'h0000_0001, 4, 0, 8'ha5, 0, 4);
        // R5 16 bytes to a short request
        run_cmd(11'h400 | 11'h040 | 11'd9, 32'h0bad_cafe, 16, 0, 8'h77, 0, 5);
        // R6 length errors
        run_cmd(11'h400 | 11'h0c0 | 11'd2, 32'h1, 4, 0, 8'h44, 0, 6);
        run_cmd(11'h400 | 11'h040 | 11'd7, 32'h2, 0, 0, 8'h00, 0, 6);
        run_cmd(11'h400 | 11'h040 | 11'd7, 32'h3, 7, 0, 8'h55, 0, 6);
        run_cmd(11'h400 | 11'h0c0 | 11'd7, 32'h4, 20, 0, 8'h66, 0, 6);
        // R7 no-response flag
        run_cmd(11'h400 | 11'd0, 32'h5, 0, 1, 8'h00, 0, 7);
        run_cmd(11'h400 | 11'h040 | 11'd8, 32'h6, 4, 1, 8'h99, 0, 7);
        // R8 silent card
        run_cmd(11'h400 | 11'h040 | 11'd1, 32'h7, 0, 0, 8'h00, 1, 8);

        // R11 write while busy is ignored
        begin
            sb_item_t it;
            it.kind = 2'(K_SENT); it.w = exp_w; it.stored = 11'd21; it.tag = 8'd11;
            sbq.push_back(it);
            cmd_word = 11'h400 | 11'd21; cmd_arg = 32'haaaa_0001; cmd_wr = 1;
            @(negedge clk);
            cmd_word = 11'h400 | 11'h0c0 | 11'd42; cmd_arg = 32'hbbbb_0002;
            @(negedge clk);
            cmd_wr = 0;
            chk(cmd_stored == (11'h400 | 11'd21), "R11 stored unchanged", cmd_stored, 11'h415);
            chk(card_arg == 32'haaaa_0001, "R11 argument unchanged", card_arg, 32'haaaa_0001);
            chk(card_index == 6'd21, "R11 index unchanged", card_index, 6'd21);
            card_done = 1;
            @(negedge clk);
            card_done = 0;
            @(negedge clk);
        end

        // R10 hold flag
        cmd_word = 11'h600 | 11'h040 | 11'd5; cmd_arg = 32'h9; cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        chk(!busy && !card_req, "R10 no issue on hold", {busy, card_req}, 0);
        chk(cmd_stored == (11'h200 | 11'h040 | 11'd5), "R10 stored with start clear", cmd_stored, 11'h245);
        repeat (5) @(negedge clk);
        chk(!busy, "R10 still idle", busy, 0);

        // R1 write with start clear stores only
        cmd_word = 11'h0c0 | 11'd33; cmd_arg = 32'h10; cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        chk(!busy && !card_req, "R1 no issue without start", {busy, card_req}, 0);
        chk(cmd_stored == (11'h0c0 | 11'd33), "R1 stored word", cmd_stored, 11'h0e1);
        repeat (3) @(negedge clk);

        chk(sbq.size() == 0, "R12 every command completed", sbq.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule